// File: doc/BRIEF.md
# Two-Strobe Transmit Word Queue

This block sits between a 16-bit host bus and a serial word transmitter. It holds up to eight 31-bit transmit words. The host builds each word in two writes. A first strobe captures the lower half. A second strobe adds the upper bits and places the complete word in the next free slot. The serializer reads the oldest word from a show-ahead head port and removes it with a one-cycle pop.

A ready flag is high whenever the queue is empty. It drops on the clock after a word is committed. When the queue is full, further commits are dropped. A second strobe that has no first strobe before it since the last commit does nothing. Parity and serial shifting belong to the downstream stage.

Top module: `txw_fifo`

## Requirements
- R1: A first-half strobe (`lo_stb`) captures `hbus[15:0]` as word bits [15:0]. The captured value is held over any number of idle cycles until a second-half strobe uses it.
- R2: A second-half strobe (`hi_stb`) that follows a first-half strobe commits the word `{hbus[14:0], low_half}` (31 bits). Bus bit 15 is ignored.
- R3: The queue holds at most 8 words, and its occupancy never goes above 8.
- R4: A commit attempted while 8 words are stored is dropped and the stored words are unchanged. That second-half strobe still uses up the pending low half.
- R5: `tx_ready` is high after reset and whenever the queue is empty. It goes low on the first clock edge after a commit into an empty queue.
- R6: Starting from an empty queue, eight words loaded in succession are all accepted and come out in the order they were loaded.
- R7: A second-half strobe with no first-half strobe since the last commit (or since reset) stores nothing.
- R8: `pop` with `pop_valid` high removes the head word. `pop` while the queue is empty has no effect.
- R9: A commit and a pop in the same cycle leave the occupancy unchanged. The popped word leaves and the committed word joins the tail.
- R10: `pop_word` shows the oldest stored word whenever `pop_valid` is high, and `pop_valid` is high exactly when the queue is not empty.
- R11: Several first-half strobes before one second-half strobe are allowed; the last captured low half is the one used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lo_stb | input | 1 | First-half load strobe, one cycle |
| hi_stb | input | 1 | Second-half load strobe, one cycle; commits the word |
| hbus | input | 16 | Host data half |
| pop | input | 1 | Serializer removes the head word |
| pop_word | output | 31 | Oldest stored word |
| pop_valid | output | 1 | Queue holds at least one word |
| tx_ready | output | 1 | Queue is empty |

## Verification
The bench builds the block with its default sizes: 16-bit halves, 31-bit words and a depth of eight. This lets it fill the queue completely from ready and push a ninth word against the full boundary. The load vectors set bus bit 15 on several upper halves, so dropping that bit is visible in each drained word. The last part of the run covers an orphan second strobe, repeated first strobes, a pop on an empty queue and a commit in the same cycle as a pop. Each is judged from the head word and from how many pops it takes to bring ready back.

// File: rtl/txw_pkg.sv
package txw_pkg;
  localparam int TXW_HALF_W = 16;
  localparam int TXW_WORD_W = 31;
  localparam int TXW_DEPTH  = 8;

  // Wrapping pointer step for any depth, power of two or not.
  function automatic int unsigned ptr_step(input int unsigned ptr, input int unsigned depth);
    return (ptr + 1 >= depth) ? 0 : ptr + 1;
  endfunction

  // Occupancy update: push and pop together cancel out.
  function automatic int unsigned occ_next(input int unsigned occ, input logic push, input logic take);
    case ({push, take})
      2'b10:   return occ + 1;
      2'b01:   return occ - 1;
      default: return occ;
    endcase
  endfunction
endpackage

// File: rtl/txw_half_latch.sv
module txw_half_latch #(
  parameter int HALF_W = txw_pkg::TXW_HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_stb,
  input  logic              hi_stb,
  input  logic [HALF_W-1:0] hbus,
  output logic [HALF_W-1:0] lo_q,
  output logic              pend_q
);
  // A second-half strobe consumes the pending half whether or not the commit lands.
  // A first-half strobe in the same cycle re-arms with fresh data.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      if (lo_stb) begin
        lo_q   <= hbus;
        pend_q <= 1'b1;
      end else if (hi_stb) begin
        pend_q <= 1'b0;
      end
    end
  end

  assert_hold_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_stb |=> $stable(lo_q));
endmodule

// File: rtl/txw_occupancy.sv
module txw_occupancy #(
  parameter int DEPTH = txw_pkg::TXW_DEPTH,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_fire,
  input  logic             pop_fire,
  output logic [CNT_W-1:0] occ,
  output logic             full,
  output logic             empty
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= CNT_W'(txw_pkg::occ_next(int'(occ), push_fire, pop_fire));
  end

  assign full  = (occ == CNT_W'(DEPTH));
  assign empty = (occ == '0);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push_fire);
  assert_pair_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && pop_fire) |=> $stable(occ));
endmodule

// File: rtl/txw_store.sv
module txw_store #(
  parameter int WORD_W = txw_pkg::TXW_WORD_W,
  parameter int DEPTH  = txw_pkg::TXW_DEPTH,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= PTR_W'(txw_pkg::ptr_step(int'(wr_ptr), DEPTH));
      if (rd_en) rd_ptr <= PTR_W'(txw_pkg::ptr_step(int'(rd_ptr), DEPTH));
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_ptr == PTR_W'(g))) mem[g] <= wr_data;
    end
  end

  assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/txw_fifo.sv
module txw_fifo #(
  parameter int HALF_W = txw_pkg::TXW_HALF_W,
  parameter int WORD_W = txw_pkg::TXW_WORD_W,
  parameter int DEPTH  = txw_pkg::TXW_DEPTH,
  localparam int HI_W  = WORD_W - HALF_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_stb,
  input  logic              hi_stb,
  input  logic [HALF_W-1:0] hbus,
  input  logic              pop,
  output logic [WORD_W-1:0] pop_word,
  output logic              pop_valid,
  output logic              tx_ready
);
  // Upper half contributes only its low HI_W bits.
  function automatic logic [WORD_W-1:0] join_word(input logic [HALF_W-1:0] lo, input logic [HALF_W-1:0] hi);
    return {hi[HI_W-1:0], lo};
  endfunction

  logic [HALF_W-1:0] lo_q;
  logic              pend_q;
  logic [CNT_W-1:0]  occ_count;
  logic              occ_full, occ_empty;
  logic              commit_fire, pop_fire;

  txw_half_latch #(.HALF_W(HALF_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .lo_stb(lo_stb), .hi_stb(hi_stb),
    .hbus(hbus), .lo_q(lo_q), .pend_q(pend_q)
  );

  assign commit_fire = hi_stb && pend_q && !occ_full;
  assign pop_fire    = pop && !occ_empty;

  txw_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst_n(rst_n), .push_fire(commit_fire), .pop_fire(pop_fire),
    .occ(occ_count), .full(occ_full), .empty(occ_empty)
  );

  txw_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(commit_fire),
    .wr_data(join_word(lo_q, hbus)), .rd_en(pop_fire), .rd_data(pop_word)
  );

  assign pop_valid = !occ_empty;
  assign tx_ready  = occ_empty;

  assert_ready_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> !tx_ready);
  assert_orphan_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_stb && !pend_q && !pop_fire) |=> (occ_count == $past(occ_count)));
  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_full && hi_stb && !pop_fire) |=> occ_full);
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !pop_valid && !commit_fire) |=> tx_ready);
endmodule

// File: tb/txw_fifo_tb.sv
module txw_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [15:0] LO_V [NV] = '{16'h0001, 16'hA5A5, 16'hFFFF, 16'h1234,
                                        16'h8000, 16'h0F0F, 16'h5555, 16'hC3C3};
  localparam logic [15:0] HI_V [NV] = '{16'h8000, 16'h7FFF, 16'hFFFF, 16'h0001,
                                        16'h8ABC, 16'h2468, 16'hAAAA, 16'h0000};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lo_stb = 1'b0, hi_stb = 1'b0, pop = 1'b0;
  logic [15:0] hbus = '0;
  logic [30:0] pop_word;
  logic        pop_valid, tx_ready;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txw_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .lo_stb(lo_stb), .hi_stb(hi_stb), .hbus(hbus),
    .pop(pop), .pop_word(pop_word), .pop_valid(pop_valid), .tx_ready(tx_ready)
  );

  function automatic logic [30:0] expect_word(input logic [15:0] lo, input logic [15:0] hi);
    logic [31:0] t;
    t = (32'(hi & 16'h7FFF) << 16) | 32'(lo);
    return t[30:0];
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_lo(input logic [15:0] v);
    @(negedge clk); lo_stb = 1'b1; hbus = v;
    @(negedge clk); lo_stb = 1'b0;
  endtask

  task automatic put_hi(input logic [15:0] v, input logic with_pop);
    @(negedge clk); hi_stb = 1'b1; hbus = v; pop = with_pop;
    @(negedge clk); hi_stb = 1'b0; pop = 1'b0;
  endtask

  task automatic take;
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_fail++;
      $display("FAIL watchdog: expired at cycle %0d", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(32'(tx_ready), 1, "R5 ready after reset");
    chk(32'(pop_valid), 0, "R10 no valid after reset");

    // Vector walk: fill to capacity from ready
    for (int i = 0; i < NV; i++) begin
      put_lo(LO_V[i]);
      put_hi(HI_V[i], 1'b0);
      chk(32'(tx_ready), 0, "R5 ready low after commit");
      chk(32'(pop_valid), 1, "R6 word accepted");
    end

    // Ninth word against a full queue
    put_lo(16'hDEAD);
    put_hi(16'h7EEF, 1'b0);
    chk(32'(pop_word), 32'(expect_word(LO_V[0], HI_V[0])), "R4 head unchanged when full");

    // Drain in order
    for (int i = 0; i < NV; i++) begin
      chk(32'(pop_valid), 1, "R3 valid while draining");
      chk(32'(pop_word), 32'(expect_word(LO_V[i], HI_V[i])), "R2 R6 R10 word order and bits");
      take();
    end
    chk(32'(tx_ready), 1, "R4 ninth word not stored, ready again");
    chk(32'(pop_valid), 0, "R8 empty after eight pops");

    // Pop on empty
    take();
    chk(32'(tx_ready), 1, "R8 empty pop ignored");

    // Orphan second half
    put_hi(16'h1234, 1'b0);
    chk(32'(tx_ready), 1, "R7 orphan second strobe stores nothing");

    // Repeated first halves with idle gap
    put_lo(16'h1111);
    put_lo(16'h2222);
    repeat (4) @(negedge clk);
    put_hi(16'h8003, 1'b0);
    chk(32'(pop_word), 32'(expect_word(16'h2222, 16'h8003)), "R11 R1 last low half used after gap");

    // Commit and pop together with one word stored
    put_lo(16'h4444);
    put_hi(16'h0055, 1'b1);
    chk(32'(pop_valid), 1, "R9 still one word");
    chk(32'(pop_word), 32'(expect_word(16'h4444, 16'h0055)), "R9 new word at head");
    take();
    chk(32'(tx_ready), 1, "R9 occupancy was unchanged by pair");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule